// File: doc/BRIEF.md
# GPIO Controller with Single-Pin Event Interrupt

This peripheral drives and samples sixteen general-purpose pins through a small 16-bit register bus. Software sets output levels and per-pin direction, reads back a sampled view of the pins, and arms one pin at a time to raise an interrupt on a chosen edge. A keypad request line from a neighbouring scanner shares the same interrupt status and mask registers, so one interrupt output serves both sources.

The armed pin is selected by an encoded event-mode word rather than a per-pin enable vector. Every pad passes through its own two-flop synchroniser with a history flop. The selected pin's edge is therefore judged against that pin's own history. The event status bit is sticky and is cleared by reading the status register. A single clock-enable control bit freezes both the pin sampling and the event capture.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: During and after reset, the output register reads 0x0000 and the direction register reads 0xFFFF, so `pad_oe` is all zeros. The event-mode register, the control register and `irq` are 0. The mask register reads 0x0003.
- R2: Writing address 0 sets `pad_out`, and writing address 1 sets the direction. A direction bit of 1 makes the pin an input and 0 makes it an output, so `pad_oe[i]` is the inverse of direction bit i. Both registers read back as written.
- R3: The input register at address 2 updates on every clock while the block is enabled. For an input pin it takes `pad_in[i]`; for an output pin it takes the driven output bit. The value is visible to a read issued one cycle after the pad changes.
- R4: Event-mode register at address 3. Bit 0 arms event detection, bits 4:1 give the pin number, and bit 5 selects the edge (1 = rising, 0 = falling). An edge of the chosen polarity on the armed pin sets status bit 1 on the third rising clock after the pad changes. An edge of the other polarity sets nothing.
- R5: Status at address 4 returns the keypad bit in bit 0 and the GPIO event bit in bit 1. A status read clears the GPIO event bit. If a new event lands in the same cycle as the read, the read returns the old value and the bit stays set.
- R6: The keypad status bit equals `kp_req` delayed by one clock. A status read does not clear it.
- R7: Mask at address 5 holds bit 0 for the keypad and bit 1 for the GPIO event, where 1 masks the source. `irq` is high exactly when some status bit is set and its mask bit is 0. A masked event is still recorded in status.
- R8: Control bit 5 at address 6 is the clock enable. While it is 0, the input register holds its value and no GPIO event is recorded. Edges that occur while it is 0 are not reported after it is set again.
- R9: Edges on pins other than the armed one are ignored. Moving the selection to a pin that is steady does not create an event, even if the new pin's level differs from the old pin's.
- R10: Read data appears on `bus_rdata` one clock after `bus_rd`. Addresses 7 and above read 0. Writes to the input and status addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pad_in | input | 16 | Pin levels from the pads |
| pad_out | output | 16 | Output levels to the pads |
| pad_oe | output | 16 | Per-pin output enable, 1 = drive |
| kp_req | input | 1 | Keypad interrupt request |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench times an armed edge to the exact cycle. It checks that the event is absent after two clocks and present after three. A design missing or adding a synchroniser stage would report one cycle late or early. The bench places a status read on the very cycle an event lands; a design that lets the clear win would lose that event silently. It also moves the selection between pins at different steady levels, which catches a design that synchronises after the pin multiplexer and reports a phantom edge. Finally, it toggles the armed pin while the clock enable is 0, which catches a design that stores a stale edge and fires once the block is enabled again.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int NPIN      = 16;
    localparam int PIN_W     = $clog2(NPIN);
    localparam int DW        = 16;
    localparam int AW        = 3;
    localparam int CLKEN_BIT = 5;

    typedef enum logic [AW-1:0] {
        RA_OUT  = 3'd0,
        RA_DIR  = 3'd1,
        RA_PIN  = 3'd2,
        RA_EVT  = 3'd3,
        RA_STAT = 3'd4,
        RA_MASK = 3'd5,
        RA_CTRL = 3'd6
    } reg_addr_e;

    // bit 5 edge polarity, bits 4:1 pin number, bit 0 arm
    typedef struct packed {
        logic             rise;
        logic [PIN_W-1:0] pin;
        logic             en;
    } evt_cfg_t;

    localparam int CFG_W = $bits(evt_cfg_t);

    // bit 1 gpio event, bit 0 keypad
    typedef struct packed {
        logic gpio;
        logic kp;
    } irq_vec_t;

    localparam int IRQ_W = $bits(irq_vec_t);

    function automatic logic [NPIN-1:0] pin_view(
        input logic [NPIN-1:0] dir,
        input logic [NPIN-1:0] drv,
        input logic [NPIN-1:0] pad
    );
        return (dir & pad) | (~dir & drv);
    endfunction

endpackage

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
    import gpio_evt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wr_data,
    output logic [NPIN-1:0]       out_q,
    output logic [NPIN-1:0]       dir_q,
    output evt_cfg_t              cfg_q,
    output irq_vec_t              mask_q,
    output logic                  clk_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            dir_q  <= '1;
            cfg_q  <= '0;
            mask_q <= '1;
            clk_en <= 1'b0;
        end else if (wr_en) begin
            case (reg_addr_e'(addr))
                RA_OUT:  out_q  <= wr_data[NPIN-1:0];
                RA_DIR:  dir_q  <= wr_data[NPIN-1:0];
                RA_EVT:  cfg_q  <= evt_cfg_t'(wr_data[CFG_W-1:0]);
                RA_MASK: mask_q <= irq_vec_t'(wr_data[IRQ_W-1:0]);
                RA_CTRL: clk_en <= wr_data[CLKEN_BIT];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_evt_edge.sv
module gpio_evt_edge
    import gpio_evt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pad,
    input  evt_cfg_t        cfg,
    output logic            hit
);

    logic [NPIN-1:0] lvl_now;
    logic [NPIN-1:0] lvl_old;

    // per-pin two-flop synchroniser plus history, so reselecting never
    // compares two different pins
    for (genvar i = 0; i < NPIN; i++) begin : g_sync
        logic [2:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[1:0], pad[i]};
        end
        assign lvl_now[i] = sh[1];
        assign lvl_old[i] = sh[2];
    end

    logic sel_now, sel_old;
    assign sel_now = lvl_now[cfg.pin];
    assign sel_old = lvl_old[cfg.pin];

    always_comb begin
        if (cfg.rise) hit = cfg.en & sel_now & ~sel_old;
        else          hit = cfg.en & ~sel_now & sel_old;
    end

endmodule

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq
    import gpio_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clk_en,
    input  logic     hit,
    input  logic     kp_req,
    input  logic     rd_stat,
    input  irq_vec_t mask,
    output irq_vec_t stat,
    output logic     irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            stat.kp   <= kp_req;
            stat.gpio <= (clk_en & hit) | (stat.gpio & ~rd_stat);
        end
    end

    assign irq = |(stat & ~mask);

endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
    import gpio_evt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    input  logic            kp_req,
    output logic            irq
);

    logic [NPIN-1:0] out_q, dir_q, in_q;
    evt_cfg_t        cfg_q;
    irq_vec_t        mask_q, stat_q;
    logic            clk_en, evt_hit, rd_stat;
    logic [DW-1:0]   rd_val;

    gpio_evt_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wr_data (bus_wdata),
        .out_q   (out_q),
        .dir_q   (dir_q),
        .cfg_q   (cfg_q),
        .mask_q  (mask_q),
        .clk_en  (clk_en)
    );

    gpio_evt_edge u_edge (
        .clk (clk),
        .rst (rst),
        .pad (pad_in),
        .cfg (cfg_q),
        .hit (evt_hit)
    );

    assign rd_stat = bus_rd && (bus_addr == RA_STAT);

    gpio_evt_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .clk_en  (clk_en),
        .hit     (evt_hit),
        .kp_req  (kp_req),
        .rd_stat (rd_stat),
        .mask    (mask_q),
        .stat    (stat_q),
        .irq     (irq)
    );

    always_ff @(posedge clk) begin
        if (rst)         in_q <= '0;
        else if (clk_en) in_q <= pin_view(dir_q, out_q, pad_in);
    end

    always_comb begin
        case (reg_addr_e'(bus_addr))
            RA_OUT:  rd_val = DW'(out_q);
            RA_DIR:  rd_val = DW'(dir_q);
            RA_PIN:  rd_val = DW'(in_q);
            RA_EVT:  rd_val = DW'(cfg_q);
            RA_STAT: rd_val = DW'(stat_q);
            RA_MASK: rd_val = DW'(mask_q);
            RA_CTRL: rd_val = DW'(clk_en) << CLKEN_BIT;
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    assign pad_out = out_q;
    assign pad_oe  = ~dir_q;

endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk
    import gpio_evt_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            bus_wr,
    input logic            bus_rd,
    input logic [AW-1:0]   bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic [NPIN-1:0] pad_out,
    input logic [NPIN-1:0] pad_oe,
    input logic [NPIN-1:0] in_q,
    input logic            kp_req,
    input logic            irq,
    input logic            kp_stat,
    input logic            gpio_stat,
    input logic            evt_hit,
    input logic            clk_en
);

    p_reset_oe_r1: assert property (@(posedge clk)
        rst |=> (pad_oe == '0) && !irq);

    p_out_write_r2: assert property (@(posedge clk) disable iff (rst)
        bus_wr && (bus_addr == RA_OUT) |=> pad_out == $past(bus_wdata[NPIN-1:0]));

    p_read_clear_r5: assert property (@(posedge clk) disable iff (rst)
        bus_rd && (bus_addr == RA_STAT) && !(evt_hit && clk_en) |=> !gpio_stat);

    p_kp_follow_r6: assert property (@(posedge clk) disable iff (rst)
        kp_req |=> kp_stat);

    p_irq_source_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (kp_stat || gpio_stat));

    p_gate_event_r8: assert property (@(posedge clk) disable iff (rst)
        !clk_en && !gpio_stat |=> !gpio_stat);

    p_gate_input_r8: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(in_q));

endmodule

bind gpio_evt_ctrl gpio_evt_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .in_q      (in_q),
    .kp_req    (kp_req),
    .irq       (irq),
    .kp_stat   (stat_q.kp),
    .gpio_stat (stat_q.gpio),
    .evt_hit   (evt_hit),
    .clk_en    (clk_en)
);

// File: tb/gpio_evt_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_evt_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_oe;
    logic        kp_req = 1'b0;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    gpio_evt_ctrl u_gpio_evt_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .kp_req    (kp_req),
        .irq       (irq)
    );

    localparam logic [2:0] A_OUT = 3'd0, A_DIR = 3'd1, A_PIN = 3'd2, A_EVT = 3'd3,
                           A_STAT = 3'd4, A_MASK = 3'd5, A_CTRL = 3'd6, A_NONE = 3'd7;

    // expected input view, built per pin from R3
    function automatic logic [15:0] model_in(logic [15:0] dir, logic [15:0] drv, logic [15:0] pad);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = dir[i] ? pad[i] : drv[i];
        return r;
    endfunction

    // event-mode word from R4 field positions
    function automatic logic [15:0] evt_word(bit arm, int pin, bit rise);
        return (16'(rise) << 5) | (16'(pin) << 1) | 16'(arm);
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(string req, logic [2:0] a, logic [15:0] exp);
        logic [15:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [15:0] d, held;
        void'($urandom(32'd20240611));
        tick(3);
        // R1 reset state, observed while reset is high and after
        check("R1 oe in reset", pad_oe, 16'h0000);
        rst = 1'b0;
        tick(1);
        check("R1 out", pad_out, 16'h0000);
        check("R1 oe", pad_oe, 16'h0000);
        check("R1 irq", 16'(irq), 16'h0);
        rd_chk("R1 dir", A_DIR, 16'hFFFF);
        rd_chk("R1 mask", A_MASK, 16'h0003);
        rd_chk("R1 ctrl", A_CTRL, 16'h0000);
        rd_chk("R1 evt", A_EVT, 16'h0000);

        // R8 enable clock, R2 out/dir
        wr(A_CTRL, 16'h0020);
        rd_chk("R8 ctrl readback", A_CTRL, 16'h0020);
        wr(A_OUT, 16'hA5C3);
        wr(A_DIR, 16'h00FF);
        check("R2 pad_out", pad_out, 16'hA5C3);
        check("R2 pad_oe", pad_oe, 16'hFF00);
        rd_chk("R2 out readback", A_OUT, 16'hA5C3);
        rd_chk("R2 dir readback", A_DIR, 16'h00FF);

        // R3 random mix of directions, drives and pads
        for (int k = 0; k < 30; k++) begin
            logic [15:0] o, dr, p;
            o = 16'($urandom); dr = 16'($urandom); p = 16'($urandom);
            wr(A_OUT, o);
            wr(A_DIR, dr);
            pad_in = p;
            tick(1);
            rd_chk("R3 input view", A_PIN, model_in(dr, o, p));
            check("R2 oe random", pad_oe, ~dr);
        end

        // R10 ignored writes and unmapped read
        wr(A_DIR, 16'hFFFF);
        pad_in = 16'h0000;
        tick(2);
        wr(A_PIN, 16'hFFFF);
        rd_chk("R10 pin write ignored", A_PIN, 16'h0000);
        wr(A_STAT, 16'hFFFF);
        rd_chk("R10 status write ignored", A_STAT, 16'h0000);
        wr(A_OUT, 16'h1234);
        rd_chk("R10 unmapped reads zero", A_NONE, 16'h0000);
        check("R10 rdata holds", bus_rdata, 16'h0000);

        // R4 rising event on pin 5, exact latency
        wr(A_MASK, 16'h0000);
        wr(A_EVT, evt_word(1, 5, 1));
        rd_chk("R4 evt readback", A_EVT, 16'h002B);
        tick(4);
        pad_in[5] = 1'b1;
        tick(2);
        check("R4 not yet after two clocks", 16'(irq), 16'h0);
        tick(1);
        check("R4 rising event", 16'(irq), 16'h1);
        rd_chk("R5 status shows gpio bit", A_STAT, 16'h0002);
        rd_chk("R5 cleared by read", A_STAT, 16'h0000);
        check("R5 irq after clear", 16'(irq), 16'h0);

        // R4 falling polarity
        wr(A_EVT, evt_word(1, 5, 0));
        tick(4);
        pad_in[5] = 1'b0;
        tick(3);
        check("R4 falling event", 16'(irq), 16'h1);
        rd(A_STAT, d);
        pad_in[5] = 1'b1;
        tick(5);
        check("R4 wrong polarity ignored", 16'(irq), 16'h0);

        // R9 other pin ignored; reselect to steady pin at other level
        wr(A_EVT, evt_word(1, 0, 1));
        tick(4);
        pad_in[9] = 1'b1;
        tick(5);
        check("R9 unselected pin ignored", 16'(irq), 16'h0);
        wr(A_EVT, evt_word(1, 9, 1));
        tick(5);
        check("R9 reselect no phantom", 16'(irq), 16'h0);
        rd_chk("R9 status empty", A_STAT, 16'h0000);

        // R7 masked event still recorded
        wr(A_MASK, 16'h0002);
        pad_in[9] = 1'b0;
        tick(4);
        pad_in[9] = 1'b1;
        tick(4);
        check("R7 masked gpio no irq", 16'(irq), 16'h0);
        rd_chk("R7 masked event recorded", A_STAT, 16'h0002);
        wr(A_MASK, 16'h0000);

        // R6 keypad level source
        kp_req = 1'b1;
        tick(2);
        check("R6 kp irq", 16'(irq), 16'h1);
        rd_chk("R6 kp status", A_STAT, 16'h0001);
        rd_chk("R6 kp not cleared", A_STAT, 16'h0001);
        kp_req = 1'b0;
        tick(2);
        check("R6 kp released", 16'(irq), 16'h0);
        wr(A_MASK, 16'h0001);
        kp_req = 1'b1;
        tick(3);
        check("R7 kp masked", 16'(irq), 16'h0);
        kp_req = 1'b0;
        tick(2);
        wr(A_MASK, 16'h0000);

        // R5 event landing in the same cycle as the status read
        pad_in[9] = 1'b0;
        tick(4);
        pad_in[9] = 1'b1;
        tick(2);
        rd_chk("R5 read sees old value", A_STAT, 16'h0000);
        check("R5 set wins over clear", 16'(irq), 16'h1);
        rd_chk("R5 event kept", A_STAT, 16'h0002);

        // R8 clock gating
        tick(2);
        rd(A_PIN, held);
        wr(A_CTRL, 16'h0000);
        pad_in = pad_in ^ 16'hF0F0;
        tick(2);
        rd_chk("R8 input held", A_PIN, held);
        pad_in[9] = 1'b0;
        tick(4);
        pad_in[9] = 1'b1;
        tick(4);
        check("R8 no event while gated", 16'(irq), 16'h0);
        wr(A_CTRL, 16'h0020);
        tick(4);
        check("R8 no stale event", 16'(irq), 16'h0);
        rd_chk("R8 status empty", A_STAT, 16'h0000);
        rd_chk("R8 input resumes", A_PIN, pad_in);

        finish_run();
    end

endmodule